// File: doc/BRIEF.md
# Atomic IO-Page Word Mover

This block sequences the bus for two instructions that copy a 16-bit value between page zero and a dedicated IO page. Each copy is one uninterrupted unit: two byte reads followed by two byte writes. The processor must not service an interrupt anywhere inside the copy. Multi-byte control registers in the IO page are therefore never observed, or left, with only one byte of a new value in place.

The decoder pulses `start_i` with the opcode, a zero-page operand and the current Y register. On that strobe the block captures the operands and raises the interrupt hold-off. It then drives the byte-wide memory bus for four cycles and pulses `done_o`. In the forward direction the data goes from page zero into the IO register selected by Y. In the reverse direction it goes from the IO register back into page zero. The low byte always moves first.

Top module: `iopg_word_mover`

## Requirements
- R1: After reset, `bus_rd_o`, `bus_wr_o`, `irq_inhibit_o` and `done_o` are all 0.
- R2: A strobe with opcode 0x44 reads the zero-page operand address, then that address plus one. Both addresses lie in page zero, so the upper address byte is 0x00.
- R3: For opcode 0x44, the byte read first is written to IO_BASE+Y. The byte read second is written to IO_BASE+Y+1.
- R4: A strobe with opcode 0x54 reads IO_BASE+Y and then IO_BASE+Y+1. It writes those bytes, in the same order, to the zero-page operand address and that address plus one.
- R5: The zero-page address for the high byte wraps inside page zero, so operand 0xFF pairs with 0x0000.
- R6: IO addresses are 16-bit sums taken modulo 65536, with IO_BASE defaulting to 0xFF00. With Y=0xFE the addresses are 0xFFFE and 0xFFFF. With Y=0xFF they are 0xFFFF and 0x0000.
- R7: The cycles after an accepted strobe are read, read, write, write. `done_o` is then high for exactly one cycle, the one after the second write.
- R8: `irq_inhibit_o` is high in the strobe cycle of an accepted move and stays high through the `done_o` cycle. It is low in the following idle cycle.
- R9: A strobe with any other opcode is ignored. It causes no bus access, no hold-off and no `done_o`.
- R10: A strobe that arrives during a move is ignored. The move finishes with the operands captured at its own strobe, and later changes on `zp_i` and `y_i` have no effect on it.
- R11: Reads and writes are never asserted together. `bus_wdata_o` carries the byte being written during each write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request strobe from the decoder |
| opcode_i | input | 8 | Opcode that selects the move direction |
| zp_i | input | 8 | Zero-page operand address |
| y_i | input | 8 | Y register, the register index in the IO page |
| bus_addr_o | output | 16 | Memory bus address |
| bus_rd_o | output | 1 | Read cycle; data is taken from `bus_rdata_i` at the clock edge |
| bus_wr_o | output | 1 | Write cycle |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, valid in the same cycle as the read |
| irq_inhibit_o | output | 1 | Interrupt acknowledge hold-off |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- reads and writes never overlap;
- any bus access or completion pulse happens under the interrupt hold-off;
- an accepted strobe is followed by a read;
- the end of the write burst is followed by a one-cycle `done_o`;
- the hold-off drops once the move ends;
- no strobe is accepted while a move is running.

Only the bench scenarios can show that the right addresses and data appear in the right order. These scenarios cover the address wrap in page zero, the carry out of the IO address, the two directions, and the fact that operands are held against later changes on the inputs.

// File: rtl/iopg_mover_pkg.sv
package iopg_mover_pkg;

  localparam int MV_AW = 16;
  localparam int MV_DW = 8;
  localparam int MV_BYTES = 2;

  typedef logic [MV_AW-1:0] mv_addr_t;
  typedef logic [MV_DW-1:0] mv_byte_t;

  typedef enum logic [2:0] {
    MV_IDLE  = 3'd0,
    MV_RD_LO = 3'd1,
    MV_RD_HI = 3'd2,
    MV_WR_LO = 3'd3,
    MV_WR_HI = 3'd4,
    MV_FIN   = 3'd5
  } mv_state_e;

  typedef enum logic {
    MV_TO_IO   = 1'b0,
    MV_FROM_IO = 1'b1
  } mv_dir_e;

  // Page-zero address of byte 'hi' of the word; wraps within the page.
  function automatic mv_addr_t zp_byte_addr(input mv_byte_t zp, input logic hi);
    mv_byte_t low_part;
    low_part = zp + {{(MV_DW-1){1'b0}}, hi};
    return {{(MV_AW-MV_DW){1'b0}}, low_part};
  endfunction

  // IO-page address of byte 'hi': base + index + hi, modulo 2**MV_AW.
  function automatic mv_addr_t io_byte_addr(input mv_addr_t base, input mv_byte_t idx,
                                            input logic hi);
    return base + {{(MV_AW-MV_DW){1'b0}}, idx} + {{(MV_AW-1){1'b0}}, hi};
  endfunction

  function automatic logic st_is_read(input mv_state_e s);
    return (s == MV_RD_LO) || (s == MV_RD_HI);
  endfunction

  function automatic logic st_is_write(input mv_state_e s);
    return (s == MV_WR_LO) || (s == MV_WR_HI);
  endfunction

  function automatic logic st_is_high(input mv_state_e s);
    return (s == MV_RD_HI) || (s == MV_WR_HI);
  endfunction

endpackage

// File: rtl/iopg_mover_ctrl.sv
module iopg_mover_ctrl
  import iopg_mover_pkg::*;
#(
  parameter mv_byte_t OPC_TO_IO   = 8'h44,
  parameter mv_byte_t OPC_FROM_IO = 8'h54
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  mv_byte_t  opcode_i,
  output mv_state_e state_o,
  output mv_dir_e   dir_o,
  output logic      accept_o
);

  mv_state_e state_q, state_d;
  mv_dir_e   dir_q;
  logic      opc_known;

  assign opc_known = (opcode_i == OPC_TO_IO) || (opcode_i == OPC_FROM_IO);
  assign accept_o  = start_i && opc_known && (state_q == MV_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MV_IDLE:  if (accept_o) state_d = MV_RD_LO;
      MV_RD_LO: state_d = MV_RD_HI;
      MV_RD_HI: state_d = MV_WR_LO;
      MV_WR_LO: state_d = MV_WR_HI;
      MV_WR_HI: state_d = MV_FIN;
      MV_FIN:   state_d = MV_IDLE;
      default:  state_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      dir_q   <= MV_TO_IO;
    end else begin
      state_q <= state_d;
      if (accept_o) dir_q <= (opcode_i == OPC_FROM_IO) ? MV_FROM_IO : MV_TO_IO;
    end
  end

  assign state_o = state_q;
  assign dir_o   = dir_q;

endmodule

// File: rtl/iopg_mover_addr.sv
module iopg_mover_addr
  import iopg_mover_pkg::*;
#(
  parameter mv_addr_t IO_BASE = 16'hFF00
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept_i,
  input  mv_byte_t  zp_i,
  input  mv_byte_t  y_i,
  input  mv_state_e state_i,
  input  mv_dir_e   dir_i,
  output mv_addr_t  addr_o
);

  mv_byte_t zp_q, y_q;
  mv_addr_t src_addr, dst_addr;
  logic     hi_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zp_q <= '0;
      y_q  <= '0;
    end else if (accept_i) begin
      zp_q <= zp_i;
      y_q  <= y_i;
    end
  end

  assign hi_sel = st_is_high(state_i);

  always_comb begin
    if (dir_i == MV_TO_IO) begin
      src_addr = zp_byte_addr(zp_q, hi_sel);
      dst_addr = io_byte_addr(IO_BASE, y_q, hi_sel);
    end else begin
      src_addr = io_byte_addr(IO_BASE, y_q, hi_sel);
      dst_addr = zp_byte_addr(zp_q, hi_sel);
    end
  end

  always_comb begin
    if (st_is_read(state_i))       addr_o = src_addr;
    else if (st_is_write(state_i)) addr_o = dst_addr;
    else                           addr_o = '0;
  end

endmodule

// File: rtl/iopg_mover_data.sv
module iopg_mover_data
  import iopg_mover_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  mv_state_e state_i,
  input  mv_byte_t  rdata_i,
  output mv_byte_t  wdata_o
);

  mv_byte_t held_q [MV_BYTES];

  for (genvar b = 0; b < MV_BYTES; b++) begin : g_byte
    localparam mv_state_e RD_ST = (b == 0) ? MV_RD_LO : MV_RD_HI;
    always_ff @(posedge clk) begin
      if (!rst_n)                held_q[b] <= '0;
      else if (state_i == RD_ST) held_q[b] <= rdata_i;
    end
  end

  always_comb begin
    unique case (state_i)
      MV_WR_LO: wdata_o = held_q[0];
      MV_WR_HI: wdata_o = held_q[1];
      default:  wdata_o = '0;
    endcase
  end

endmodule

// File: rtl/iopg_word_mover.sv
module iopg_word_mover #(
  parameter logic [15:0] IO_BASE     = 16'hFF00,
  parameter logic [7:0]  OPC_TO_IO   = 8'h44,
  parameter logic [7:0]  OPC_FROM_IO = 8'h54
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [7:0]  opcode_i,
  input  logic [7:0]  zp_i,
  input  logic [7:0]  y_i,
  output logic [15:0] bus_addr_o,
  output logic        bus_rd_o,
  output logic        bus_wr_o,
  output logic [7:0]  bus_wdata_o,
  input  logic [7:0]  bus_rdata_i,
  output logic        irq_inhibit_o,
  output logic        done_o
);
  import iopg_mover_pkg::*;

  mv_state_e state_w;
  mv_dir_e   dir_w;
  logic      accept_w;
  logic      busy_w;

  iopg_mover_ctrl #(
    .OPC_TO_IO  (OPC_TO_IO),
    .OPC_FROM_IO(OPC_FROM_IO)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .opcode_i(opcode_i),
    .state_o (state_w),
    .dir_o   (dir_w),
    .accept_o(accept_w)
  );

  iopg_mover_addr #(
    .IO_BASE(IO_BASE)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept_i(accept_w),
    .zp_i    (zp_i),
    .y_i     (y_i),
    .state_i (state_w),
    .dir_i   (dir_w),
    .addr_o  (bus_addr_o)
  );

  iopg_mover_data u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .state_i(state_w),
    .rdata_i(bus_rdata_i),
    .wdata_o(bus_wdata_o)
  );

  assign busy_w        = (state_w != MV_IDLE);
  assign bus_rd_o      = st_is_read(state_w);
  assign bus_wr_o      = st_is_write(state_w);
  assign done_o        = (state_w == MV_FIN);
  assign irq_inhibit_o = accept_w || busy_w;

endmodule

// File: rtl/iopg_word_mover_chk.sv
module iopg_word_mover_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_rd_o,
  input logic bus_wr_o,
  input logic irq_inhibit_o,
  input logic done_o,
  input logic accept_w
);

  // R11
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o));

  // R8
  inhibit_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_o || bus_wr_o || done_o) |-> irq_inhibit_o);

  // R7
  accept_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> bus_rd_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  write_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_o) |-> done_o);

  // R8
  inhibit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!irq_inhibit_o || accept_w));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> !(bus_rd_o || bus_wr_o || done_o));

endmodule

bind iopg_word_mover iopg_word_mover_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_rd_o     (bus_rd_o),
  .bus_wr_o     (bus_wr_o),
  .irq_inhibit_o(irq_inhibit_o),
  .done_o       (done_o),
  .accept_w     (accept_w)
);

// File: tb/iopg_word_mover_tb.sv
`timescale 1ns/1ps
module iopg_word_mover_tb;

  localparam logic [15:0] BASE = 16'hFF00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  opcode_i, zp_i, y_i;
  logic [15:0] bus_addr_o;
  logic        bus_rd_o, bus_wr_o, irq_inhibit_o, done_o;
  logic [7:0]  bus_wdata_o, bus_rdata_i;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_model(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
  endfunction

  assign bus_rdata_i = mem_model(bus_addr_o);

  iopg_word_mover u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .opcode_i     (opcode_i),
    .zp_i         (zp_i),
    .y_i          (y_i),
    .bus_addr_o   (bus_addr_o),
    .bus_rd_o     (bus_rd_o),
    .bus_wr_o     (bus_wr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_rdata_i  (bus_rdata_i),
    .irq_inhibit_o(irq_inhibit_o),
    .done_o       (done_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One move; optionally a second strobe arrives while busy (R10).
  task automatic run_move(input logic [7:0] opc, input logic [7:0] zp,
                          input logic [7:0] y, input bit poke, input string req);
    logic [15:0] s_lo, s_hi, d_lo, d_hi;
    logic [15:0] zlo, zhi, ilo, ihi;
    logic [7:0]  b_lo, b_hi;
    zlo = {8'h00, zp};
    zhi = {8'h00, 8'(zp + 8'd1)};
    ilo = 16'(BASE + {8'h00, y});
    ihi = 16'(BASE + {8'h00, y} + 16'd1);
    if (opc == 8'h44) begin s_lo = zlo; s_hi = zhi; d_lo = ilo; d_hi = ihi; end
    else              begin s_lo = ilo; s_hi = ihi; d_lo = zlo; d_hi = zhi; end
    b_lo = mem_model(s_lo);
    b_hi = mem_model(s_hi);

    @(negedge clk);
    start_i = 1'b1; opcode_i = opc; zp_i = zp; y_i = y;
    #1 chk({req, "/R8"}, "inhibit in strobe cycle", 16'(irq_inhibit_o), 16'd1);
    @(negedge clk);
    start_i = 1'b0; zp_i = ~zp; y_i = ~y;
    #1 chk({req, "/R7"}, "rd first", 16'(bus_rd_o), 16'd1);
    chk(req, "addr read low", bus_addr_o, s_lo);
    @(negedge clk);
    if (poke) begin start_i = 1'b1; opcode_i = (opc == 8'h44) ? 8'h54 : 8'h44; end
    #1 chk({req, "/R7"}, "rd second", 16'(bus_rd_o), 16'd1);
    chk(req, "addr read high", bus_addr_o, s_hi);
    @(negedge clk);
    start_i = 1'b0;
    #1 chk({req, "/R11"}, "wr first, no rd", {14'd0, bus_rd_o, bus_wr_o}, 16'd1);
    chk(req, "addr write low", bus_addr_o, d_lo);
    chk({req, "/R11"}, "wdata low", 16'(bus_wdata_o), 16'(b_lo));
    @(negedge clk);
    #1 chk({req, "/R7"}, "wr second", 16'(bus_wr_o), 16'd1);
    chk(req, "addr write high", bus_addr_o, d_hi);
    chk({req, "/R11"}, "wdata high", 16'(bus_wdata_o), 16'(b_hi));
    @(negedge clk);
    #1 chk({req, "/R7"}, "done cycle {done,inh,rd,wr}",
           {12'd0, done_o, irq_inhibit_o, bus_rd_o, bus_wr_o}, 16'b1100);
    @(negedge clk);
    #1 chk({req, "/R8"}, "idle after {done,inh,rd,wr}",
           {12'd0, done_o, irq_inhibit_o, bus_rd_o, bus_wr_o}, 16'b0000);
  endtask

  task automatic run_ignored(input logic [7:0] opc);
    @(negedge clk);
    start_i = 1'b1; opcode_i = opc; zp_i = 8'h12; y_i = 8'h34;
    #1 chk("R9", "inhibit on unknown opcode", 16'(irq_inhibit_o), 16'd0);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      #1 chk("R9", "quiet {done,inh,rd,wr}",
             {12'd0, done_o, irq_inhibit_o, bus_rd_o, bus_wr_o}, 16'd0);
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start_i = 1'b0; opcode_i = 8'h00; zp_i = 8'h00; y_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1", "reset {done,inh,rd,wr}",
           {12'd0, done_o, irq_inhibit_o, bus_rd_o, bus_wr_o}, 16'd0);
  endtask

  initial begin
    test_reset();
    run_move(8'h44, 8'h20, 8'h03, 1'b0, "R2/R3");
    run_move(8'h54, 8'h40, 8'h10, 1'b0, "R4");
    run_move(8'h44, 8'hFF, 8'h07, 1'b0, "R5");
    run_move(8'h54, 8'hFF, 8'h22, 1'b0, "R5/R4");
    run_move(8'h44, 8'h33, 8'hFE, 1'b0, "R6");
    run_move(8'h54, 8'h34, 8'hFF, 1'b0, "R6/R4");
    run_move(8'h44, 8'h81, 8'h05, 1'b1, "R10");
    run_ignored(8'hEA);
    run_ignored(8'h45);
    run_move(8'h54, 8'h00, 8'h00, 1'b1, "R10/R4");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule